// File: doc/BRIEF.md
# CCD Line-Binning Clock Sequencer

This block produces the full set of drive clocks for a two-phase full-frame CCD read out in line-binning mode. A single start pulse launches one frame. The frame begins with an exposure interval in which the shutter flag is raised. The whole image area is then clocked down into the horizontal register by a burst of vertical transfers, which includes extra rows for the bevelled edge of the array. After a guard interval the horizontal register is shifted out pixel by pixel. The sequencer raises a done pulse when the last pixel period ends and then waits for the next start.

During readout every pixel period carries one reset-gate pulse. A sample strobe follows each reset pulse at a programmable distance. The strobe comes with the pixel's position in the line and a flag that marks the dummy positions at both ends of the line. All durations are given in system clocks. They are captured when a frame is accepted, and any value outside its legal window is pulled to the nearest legal value. Analog level shifting, correlated double sampling and conversion sit outside this block.

Top module: `ccd_lb_seq`

## Requirements
- R1: `shutter_o` is high for exactly the latched exposure length (clocks) once per frame, and is low whenever `v2_o`, `h1_o`, `h2_o` or `rg_o` is high.
- R2: Each frame issues exactly N_ROW_ACT + N_ROW_BEVEL vertical transfers (rising edges of `v2_o`), and `v2_o` stays high for exactly the latched vertical width each time.
- R3: `v1_o` is always the inverse of `v2_o`, and `tg_o` is always equal to `v2_o`. Outside the vertical transfer phase `v1_o` = 1 and `v2_o` = 0.
- R4: Readout issues exactly N_DUMMY_LEAD + N_SIGNAL + N_DUMMY_TRAIL horizontal periods. In each period `h1_o` is high for the latched horizontal width and then `h2_o` is high for the same width (50 % duty). `h1_o` and `h2_o` are never both high, and `sg_o` always equals `h2_o`.
- R5: The first rise of `h1_o` comes exactly (vertical width + overlap) clocks after the last fall of `tg_o`. No horizontal clock is high while `v2_o` is high.
- R6: `rg_o` rises once at the start of every horizontal period and stays high for the latched reset width, which is clamped to [MIN_RG, horizontal width].
- R7: `pix_valid_o` pulses for one clock exactly (reset width + sample delay) clocks after each rise of `rg_o`, never while `rg_o` is high. The sample delay is clamped to at most horizontal width − 1. `pix_idx_o` counts 0, 1, … up to the last pixel across the line.
- R8: `pix_dummy_o` is 1 for indices below N_DUMMY_LEAD or at or above N_DUMMY_LEAD + N_SIGNAL, and 0 for the N_SIGNAL indices in between.
- R9: Timing inputs are captured only when a frame is accepted. Exposure 0 becomes 1, vertical width is clamped to [MIN_VW, MAX_VW], horizontal width to at least MIN_HW and overlap to at least MIN_OVR. Input changes during a frame have no effect on it.
- R10: A start during a frame is ignored. `done_o` is a single-clock pulse in the clock that follows the last horizontal period. A start given in the same clock as `done_o` is accepted and begins a new frame.
- R11: After reset: `v1_o` = 1, all other outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame start pulse |
| cfg_integ_i | input | INT_W | Exposure length in clocks |
| cfg_vwidth_i | input | CNT_W | Vertical phase width in clocks |
| cfg_hwidth_i | input | CNT_W | Horizontal phase width in clocks |
| cfg_overlap_i | input | CNT_W | Guard clocks between vertical and horizontal clocking |
| cfg_rgwidth_i | input | CNT_W | Reset-gate pulse width in clocks |
| cfg_smpdly_i | input | CNT_W | Strobe delay after the reset pulse ends |
| shutter_o | output | 1 | Shutter open request |
| v1_o | output | 1 | Vertical clock phase 1 |
| v2_o | output | 1 | Vertical clock phase 2 |
| tg_o | output | 1 | Transfer gate (follows phase 2) |
| h1_o | output | 1 | Horizontal clock phase 1 |
| h2_o | output | 1 | Horizontal clock phase 2 |
| sg_o | output | 1 | Summing gate (follows phase 2) |
| rg_o | output | 1 | Reset gate |
| pix_valid_o | output | 1 | Sample strobe |
| pix_dummy_o | output | 1 | Strobe belongs to a dummy position |
| pix_idx_o | output | IDX_W | Position of the sample in the line |
| done_o | output | 1 | Frame-complete pulse |

## Verification
The end of a frame and the acceptance of a new start can fall in the same clock, because the sequencer is already idle while `done_o` is high. The bench provokes this by raising `start_i` in the very clock in which it sees `done_o`. It then judges the first frame by its complete counts and the second by a full and correctly timed set of vertical transfers, horizontal periods and strobes with a single done pulse. A second collision is a start that lands in the middle of a frame together with new timing inputs. That frame must keep its original widths and must not be followed by a spurious second frame.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_EXPO  = 3'd1,
    ST_VXFER = 3'd2,
    ST_GUARD = 3'd3,
    ST_HREAD = 3'd4
  } seq_state_e;
endpackage

// File: rtl/ccd_cfg_latch.sv
module ccd_cfg_latch #(
  parameter int CNT_W   = 16,
  parameter int INT_W   = 32,
  parameter int MIN_VW  = 1200,
  parameter int MAX_VW  = 12000,
  parameter int MIN_HW  = 100,
  parameter int MIN_OVR = 600,
  parameter int MIN_RG  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [INT_W-1:0] raw_integ,
  input  logic [CNT_W-1:0] raw_vw,
  input  logic [CNT_W-1:0] raw_hw,
  input  logic [CNT_W-1:0] raw_ovr,
  input  logic [CNT_W-1:0] raw_rg,
  input  logic [CNT_W-1:0] raw_sd,
  output logic [INT_W-1:0] q_integ,
  output logic [CNT_W-1:0] q_vw,
  output logic [CNT_W-1:0] q_hw,
  output logic [CNT_W-1:0] q_ovr,
  output logic [CNT_W-1:0] q_rg,
  output logic [CNT_W-1:0] q_sd
);
  localparam logic [CNT_W-1:0] LO_VW  = CNT_W'(MIN_VW);
  localparam logic [CNT_W-1:0] HI_VW  = CNT_W'(MAX_VW);
  localparam logic [CNT_W-1:0] LO_HW  = CNT_W'(MIN_HW);
  localparam logic [CNT_W-1:0] LO_OVR = CNT_W'(MIN_OVR);
  localparam logic [CNT_W-1:0] LO_RG  = CNT_W'(MIN_RG);

  logic [INT_W-1:0] c_integ;
  logic [CNT_W-1:0] c_vw, c_hw, c_ovr, c_rg_lo, c_rg, c_sd;

  always_comb begin
    c_integ = (raw_integ == '0) ? INT_W'(1) : raw_integ;
    if (raw_vw < LO_VW)      c_vw = LO_VW;
    else if (raw_vw > HI_VW) c_vw = HI_VW;
    else                     c_vw = raw_vw;
    c_hw    = (raw_hw  < LO_HW)  ? LO_HW  : raw_hw;
    c_ovr   = (raw_ovr < LO_OVR) ? LO_OVR : raw_ovr;
    c_rg_lo = (raw_rg  < LO_RG)  ? LO_RG  : raw_rg;
    c_rg    = (c_rg_lo > c_hw)   ? c_hw   : c_rg_lo;
    c_sd    = (raw_sd > (c_hw - CNT_W'(1))) ? (c_hw - CNT_W'(1)) : raw_sd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_integ <= INT_W'(1);
      q_vw    <= LO_VW;
      q_hw    <= LO_HW;
      q_ovr   <= LO_OVR;
      q_rg    <= LO_RG;
      q_sd    <= '0;
    end else if (load) begin
      q_integ <= c_integ;
      q_vw    <= c_vw;
      q_hw    <= c_hw;
      q_ovr   <= c_ovr;
      q_rg    <= c_rg;
      q_sd    <= c_sd;
    end
  end
endmodule

// File: rtl/ccd_frame_fsm.sv
module ccd_frame_fsm
  import ccd_seq_pkg::*;
#(
  parameter int NROWS = 128,
  parameter int NPIX  = 1044,
  parameter int CNT_W = 16,
  parameter int INT_W = 32,
  localparam int TW    = (INT_W > CNT_W + 1) ? INT_W : CNT_W + 1,
  localparam int ROW_W = (NROWS > 1) ? $clog2(NROWS) : 1,
  localparam int IDX_W = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [INT_W-1:0] integ,
  input  logic [CNT_W-1:0] vw,
  input  logic [CNT_W-1:0] hw,
  input  logic [CNT_W-1:0] ovr,
  output seq_state_e       st,
  output logic [TW-1:0]    tmr,
  output logic [IDX_W-1:0] pix,
  output logic             load,
  output logic             line_end
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NROWS - 1);
  localparam logic [IDX_W-1:0] PIX_LAST = IDX_W'(NPIX - 1);

  logic [ROW_W-1:0] row;
  logic [TW-1:0]    integ_w, vper, hper, ovr_w, tmr_inc;

  assign integ_w = TW'(integ);
  assign vper    = TW'(vw) << 1;
  assign hper    = TW'(hw) << 1;
  assign ovr_w   = TW'(ovr);
  assign tmr_inc = tmr + TW'(1);

  assign load     = (st == ST_IDLE) && start_i;
  assign line_end = (st == ST_HREAD) && (tmr_inc == hper) && (pix == PIX_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      tmr <= '0;
      row <= '0;
      pix <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            st  <= ST_EXPO;
            tmr <= '0;
          end
        end
        ST_EXPO: begin
          if (tmr_inc == integ_w) begin
            st  <= ST_VXFER;
            tmr <= '0;
            row <= '0;
          end else begin
            tmr <= tmr_inc;
          end
        end
        ST_VXFER: begin
          if (tmr_inc == vper) begin
            tmr <= '0;
            if (row == ROW_LAST) st <= ST_GUARD;
            else                 row <= row + ROW_W'(1);
          end else begin
            tmr <= tmr_inc;
          end
        end
        ST_GUARD: begin
          if (tmr_inc == ovr_w) begin
            st  <= ST_HREAD;
            tmr <= '0;
            pix <= '0;
          end else begin
            tmr <= tmr_inc;
          end
        end
        ST_HREAD: begin
          if (tmr_inc == hper) begin
            tmr <= '0;
            if (pix == PIX_LAST) st <= ST_IDLE;
            else                 pix <= pix + IDX_W'(1);
          end else begin
            tmr <= tmr_inc;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ccd_drive_out.sv
module ccd_drive_out
  import ccd_seq_pkg::*;
#(
  parameter int N_LEAD = 10,
  parameter int N_SIG  = 1024,
  parameter int CNT_W  = 16,
  parameter int TW     = 17,
  parameter int IDX_W  = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  seq_state_e       st,
  input  logic [TW-1:0]    tmr,
  input  logic [IDX_W-1:0] pix,
  input  logic             line_end,
  input  logic [CNT_W-1:0] vw,
  input  logic [CNT_W-1:0] hw,
  input  logic [CNT_W-1:0] rg,
  input  logic [CNT_W-1:0] sd,
  output logic             shutter_o,
  output logic             v1_o,
  output logic             v2_o,
  output logic             tg_o,
  output logic             h1_o,
  output logic             h2_o,
  output logic             sg_o,
  output logic             rg_o,
  output logic             pix_valid_o,
  output logic             pix_dummy_o,
  output logic [IDX_W-1:0] pix_idx_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] SIG_FIRST = IDX_W'(N_LEAD);
  localparam logic [IDX_W-1:0] SIG_END   = IDX_W'(N_LEAD + N_SIG);

  logic in_v, in_h, v2_n, h1_n, rg_n, val_n, dum_n;

  always_comb begin
    in_v  = (st == ST_VXFER);
    in_h  = (st == ST_HREAD);
    v2_n  = in_v && (tmr < TW'(vw));
    h1_n  = in_h && (tmr < TW'(hw));
    rg_n  = in_h && (tmr < TW'(rg));
    val_n = in_h && (tmr == (TW'(rg) + TW'(sd)));
    dum_n = (pix < SIG_FIRST) || (pix >= SIG_END);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shutter_o   <= 1'b0;
      v1_o        <= 1'b1;
      v2_o        <= 1'b0;
      tg_o        <= 1'b0;
      h1_o        <= 1'b0;
      h2_o        <= 1'b0;
      sg_o        <= 1'b0;
      rg_o        <= 1'b0;
      pix_valid_o <= 1'b0;
      pix_dummy_o <= 1'b0;
      pix_idx_o   <= '0;
      done_o      <= 1'b0;
    end else begin
      shutter_o   <= (st == ST_EXPO);
      v1_o        <= ~v2_n;
      v2_o        <= v2_n;
      tg_o        <= v2_n;
      h1_o        <= h1_n;
      h2_o        <= in_h && !h1_n;
      sg_o        <= in_h && !h1_n;
      rg_o        <= rg_n;
      pix_valid_o <= val_n;
      done_o      <= line_end;
      if (val_n) begin
        pix_dummy_o <= dum_n;
        pix_idx_o   <= pix;
      end
    end
  end
endmodule

// File: rtl/ccd_lb_seq.sv
module ccd_lb_seq
  import ccd_seq_pkg::*;
#(
  parameter int N_ROW_ACT     = 122,
  parameter int N_ROW_BEVEL   = 6,
  parameter int N_DUMMY_LEAD  = 10,
  parameter int N_SIGNAL      = 1024,
  parameter int N_DUMMY_TRAIL = 10,
  parameter int CNT_W         = 16,
  parameter int INT_W         = 32,
  parameter int MIN_VW        = 1200,
  parameter int MAX_VW        = 12000,
  parameter int MIN_HW        = 100,
  parameter int MIN_OVR       = 600,
  parameter int MIN_RG        = 2,
  localparam int NROWS = N_ROW_ACT + N_ROW_BEVEL,
  localparam int NPIX  = N_DUMMY_LEAD + N_SIGNAL + N_DUMMY_TRAIL,
  localparam int IDX_W = (NPIX > 1) ? $clog2(NPIX) : 1,
  localparam int TW    = (INT_W > CNT_W + 1) ? INT_W : CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [INT_W-1:0] cfg_integ_i,
  input  logic [CNT_W-1:0] cfg_vwidth_i,
  input  logic [CNT_W-1:0] cfg_hwidth_i,
  input  logic [CNT_W-1:0] cfg_overlap_i,
  input  logic [CNT_W-1:0] cfg_rgwidth_i,
  input  logic [CNT_W-1:0] cfg_smpdly_i,
  output logic             shutter_o,
  output logic             v1_o,
  output logic             v2_o,
  output logic             tg_o,
  output logic             h1_o,
  output logic             h2_o,
  output logic             sg_o,
  output logic             rg_o,
  output logic             pix_valid_o,
  output logic             pix_dummy_o,
  output logic [IDX_W-1:0] pix_idx_o,
  output logic             done_o
);
  seq_state_e       st;
  logic [TW-1:0]    tmr;
  logic [IDX_W-1:0] pix;
  logic             load, line_end;
  logic [INT_W-1:0] l_integ;
  logic [CNT_W-1:0] l_vw, l_hw, l_ovr, l_rg, l_sd;

  ccd_cfg_latch #(
    .CNT_W(CNT_W), .INT_W(INT_W), .MIN_VW(MIN_VW), .MAX_VW(MAX_VW),
    .MIN_HW(MIN_HW), .MIN_OVR(MIN_OVR), .MIN_RG(MIN_RG)
  ) u_cfg (
    .clk(clk), .rst(rst), .load(load),
    .raw_integ(cfg_integ_i), .raw_vw(cfg_vwidth_i), .raw_hw(cfg_hwidth_i),
    .raw_ovr(cfg_overlap_i), .raw_rg(cfg_rgwidth_i), .raw_sd(cfg_smpdly_i),
    .q_integ(l_integ), .q_vw(l_vw), .q_hw(l_hw),
    .q_ovr(l_ovr), .q_rg(l_rg), .q_sd(l_sd)
  );

  ccd_frame_fsm #(
    .NROWS(NROWS), .NPIX(NPIX), .CNT_W(CNT_W), .INT_W(INT_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i),
    .integ(l_integ), .vw(l_vw), .hw(l_hw), .ovr(l_ovr),
    .st(st), .tmr(tmr), .pix(pix), .load(load), .line_end(line_end)
  );

  ccd_drive_out #(
    .N_LEAD(N_DUMMY_LEAD), .N_SIG(N_SIGNAL), .CNT_W(CNT_W), .TW(TW), .IDX_W(IDX_W)
  ) u_out (
    .clk(clk), .rst(rst), .st(st), .tmr(tmr), .pix(pix), .line_end(line_end),
    .vw(l_vw), .hw(l_hw), .rg(l_rg), .sd(l_sd),
    .shutter_o(shutter_o), .v1_o(v1_o), .v2_o(v2_o), .tg_o(tg_o),
    .h1_o(h1_o), .h2_o(h2_o), .sg_o(sg_o), .rg_o(rg_o),
    .pix_valid_o(pix_valid_o), .pix_dummy_o(pix_dummy_o),
    .pix_idx_o(pix_idx_o), .done_o(done_o)
  );
endmodule

// File: rtl/ccd_seq_chk.sv
module ccd_seq_chk #(
  parameter int IDX_W = 11,
  parameter int NPIX  = 1044
) (
  input logic             clk,
  input logic             rst,
  input logic             shutter,
  input logic             v1,
  input logic             v2,
  input logic             tg,
  input logic             h1,
  input logic             h2,
  input logic             sg,
  input logic             rg,
  input logic             pv,
  input logic [IDX_W-1:0] idx,
  input logic             done
);
  logic [IDX_W-1:0] last_idx;
  logic             seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_idx <= '0;
      seen     <= 1'b0;
    end else if (done) begin
      seen <= 1'b0;
    end else if (pv) begin
      last_idx <= idx;
      seen     <= 1'b1;
    end
  end

  AST_SHUTTER_QUIET: assert property (@(posedge clk) disable iff (rst) shutter |-> !(v2 || h1 || h2 || rg)); // R1
  AST_V_COMPLEMENT:  assert property (@(posedge clk) disable iff (rst) (v1 != v2) && (tg == v2)); // R3
  AST_H_EXCLUSIVE:   assert property (@(posedge clk) disable iff (rst) !(h1 && h2) && (sg == h2)); // R4
  AST_H_AFTER_V:     assert property (@(posedge clk) disable iff (rst) (h1 || h2) |-> !v2); // R5
  AST_STROBE_NO_RG:  assert property (@(posedge clk) disable iff (rst) pv |-> !rg); // R7
  AST_IDX_STEP:      assert property (@(posedge clk) disable iff (rst) (pv && idx != '0) |-> (seen && idx == last_idx + IDX_W'(1))); // R7
  AST_DONE_SINGLE:   assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
  AST_DONE_AT_END:   assert property (@(posedge clk) disable iff (rst) done |-> (seen && last_idx == IDX_W'(NPIX - 1))); // R10
endmodule

bind ccd_lb_seq ccd_seq_chk #(.IDX_W(IDX_W), .NPIX(NPIX)) u_chk (
  .clk(clk), .rst(rst), .shutter(shutter_o), .v1(v1_o), .v2(v2_o), .tg(tg_o),
  .h1(h1_o), .h2(h2_o), .sg(sg_o), .rg(rg_o), .pv(pix_valid_o),
  .idx(pix_idx_o), .done(done_o)
);

// File: tb/test_ccd_lb_seq.sv
`timescale 1ns/100ps
module test_ccd_lb_seq;
  localparam int ACT = 5, BEV = 2, LEAD = 2, SIG = 6, TRAIL = 2;
  localparam int CW = 8, IW = 8;
  localparam int NR = ACT + BEV, NP = LEAD + SIG + TRAIL;
  localparam int P_MIN_VW = 3, P_MAX_VW = 8, P_MIN_HW = 2, P_MIN_OVR = 4, P_MIN_RG = 1;
  localparam int IXW = $clog2(NP);

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [IW-1:0] c_int = 8'd5;
  logic [CW-1:0] c_vw = 8'd4, c_hw = 8'd3, c_ovr = 8'd5, c_rg = 8'd2, c_sd = 8'd1;
  logic shutter, v1, v2, tg, h1, h2, sg, rg, pv, pdum, done;
  logic [IXW-1:0] pidx;

  always #2.5 clk = ~clk;

  ccd_lb_seq #(
    .N_ROW_ACT(ACT), .N_ROW_BEVEL(BEV), .N_DUMMY_LEAD(LEAD), .N_SIGNAL(SIG),
    .N_DUMMY_TRAIL(TRAIL), .CNT_W(CW), .INT_W(IW), .MIN_VW(P_MIN_VW),
    .MAX_VW(P_MAX_VW), .MIN_HW(P_MIN_HW), .MIN_OVR(P_MIN_OVR), .MIN_RG(P_MIN_RG)
  ) i_ccd_lb_seq (
    .clk(clk), .rst(rst), .start_i(start), .cfg_integ_i(c_int),
    .cfg_vwidth_i(c_vw), .cfg_hwidth_i(c_hw), .cfg_overlap_i(c_ovr),
    .cfg_rgwidth_i(c_rg), .cfg_smpdly_i(c_sd),
    .shutter_o(shutter), .v1_o(v1), .v2_o(v2), .tg_o(tg), .h1_o(h1), .h2_o(h2),
    .sg_o(sg), .rg_o(rg), .pix_valid_o(pv), .pix_dummy_o(pdum),
    .pix_idx_o(pidx), .done_o(done)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  int e_vw = 0, e_hw = 0, e_rg = 0, e_sd = 0;
  int n_vp, n_vbad, n_comp, n_hp, n_hbad, n_shr, sh_len, n_shov;
  int n_rg, n_rgbad, n_val, n_idxbad, n_dumbad, n_dlybad, n_done, gap;
  int rv2 = 0, rh1 = 0, rh2 = 0, rrg = 0, rsh = 0, srg = 0, tgap = 0;
  bit gapping = 0;
  logic p_v2 = 0, p_h1 = 0, p_h2 = 0, p_rg = 0, p_sh = 0, p_tg = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_stats();
    n_vp = 0; n_vbad = 0; n_comp = 0; n_hp = 0; n_hbad = 0; n_shr = 0; sh_len = -1;
    n_shov = 0; n_rg = 0; n_rgbad = 0; n_val = 0; n_idxbad = 0; n_dumbad = 0;
    n_dlybad = 0; n_done = 0; gap = -1;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (v2 && !p_v2) n_vp++;
      if (v2) rv2++; else begin if (p_v2 && rv2 != e_vw) n_vbad++; rv2 = 0; end
      if (h1 && !p_h1) n_hp++;
      if (h1) rh1++; else begin if (p_h1 && rh1 != e_hw) n_hbad++; rh1 = 0; end
      if (h2) rh2++; else begin if (p_h2 && rh2 != e_hw) n_hbad++; rh2 = 0; end
      if ((v1 == v2) || (tg != v2) || (sg != h2) || (h1 && h2)) n_comp++;
      if (shutter && !p_sh) n_shr++;
      if (shutter) rsh++; else begin if (p_sh) sh_len = rsh; rsh = 0; end
      if (shutter && (v2 || h1 || h2 || rg)) n_shov++;
      if (rg && !p_rg) begin n_rg++; srg = 0; end else srg++;
      if (rg) rrg++; else begin if (p_rg && rrg != e_rg) n_rgbad++; rrg = 0; end
      if (pv) begin
        if (srg != e_rg + e_sd || rg) n_dlybad++;
        if (int'(pidx) != n_val) n_idxbad++;
        if (pdum != ((int'(pidx) < LEAD) || (int'(pidx) >= LEAD + SIG))) n_dumbad++;
        n_val++;
      end
      if (!tg && p_tg) begin tgap = 1; gapping = 1; end
      else if (gapping && !h1) tgap++;
      if (h1 && !p_h1 && gapping) begin gap = tgap; gapping = 0; end
      if (done) n_done++;
    end
    p_v2 = v2; p_h1 = h1; p_h2 = h2; p_rg = rg; p_sh = shutter; p_tg = tg;
  end

  task automatic set_cfg(input int i, vw, hw, ov, r, s);
    c_int = IW'(i); c_vw = CW'(vw); c_hw = CW'(hw); c_ovr = CW'(ov); c_rg = CW'(r); c_sd = CW'(s);
  endtask

  task automatic pulse_start();
    @(negedge clk); #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
  endtask

  // waits for done; if chain, raises start in the done clock
  task automatic wait_done(input bit chain, input string tag);
    int t = 0;
    while (n_done == 0 && t < 5000) begin @(negedge clk); #1 t++; end
    check(n_done == 1, {tag, " R10 done seen"}, n_done, 1);
    if (chain) start = 1'b1;
  endtask

  task automatic check_frame(input string tag, input int x_int, x_ovr);
    check(n_shr == 1 && sh_len == x_int, {tag, " R1 exposure length"}, sh_len, x_int);
    check(n_shov == 0, {tag, " R1 shutter closed while clocking"}, n_shov, 0);
    check(n_vp == NR, {tag, " R2 vertical count"}, n_vp, NR);
    check(n_vbad == 0, {tag, " R2 vertical width"}, n_vbad, 0);
    check(n_comp == 0, {tag, " R3 phase relations"}, n_comp, 0);
    check(n_hp == NP, {tag, " R4 horizontal count"}, n_hp, NP);
    check(n_hbad == 0, {tag, " R4 horizontal width"}, n_hbad, 0);
    check(gap == e_vw + x_ovr, {tag, " R5 overlap gap"}, gap, e_vw + x_ovr);
    check(n_rg == NP && n_rgbad == 0, {tag, " R6 reset pulses"}, n_rg * 100 + n_rgbad, NP * 100);
    check(n_val == NP && n_dlybad == 0, {tag, " R7 strobe timing"}, n_val * 100 + n_dlybad, NP * 100);
    check(n_idxbad == 0, {tag, " R7 index order"}, n_idxbad, 0);
    check(n_dumbad == 0, {tag, " R8 dummy flag"}, n_dumbad, 0);
  endtask

  task automatic run_frame(input string tag, input int ci, cv, ch, co, cr, cs,
                           input int xi, xv, xh, xo, xr, xs, input bit disturb);
    set_cfg(ci, cv, ch, co, cr, cs);
    e_vw = xv; e_hw = xh; e_rg = xr; e_sd = xs;
    clr_stats();
    pulse_start();
    if (disturb) begin
      repeat (8) @(negedge clk);
      #1 set_cfg(ci + 3, cv + 3, ch + 3, co + 3, cr + 1, cs + 1);
      start = 1'b1;
      @(negedge clk); #1 start = 1'b0;
    end
    wait_done(1'b0, tag);
    repeat (disturb ? 60 : 4) @(negedge clk);
    #1;
    check_frame(tag, xi, xo);
    if (disturb) check(n_shr == 1 && n_done == 1, {tag, " R10 stray start ignored"}, n_shr * 10 + n_done, 11);
  endtask

  task automatic t_reset();
    check(v1 == 1'b1, "R11 v1 after reset", int'(v1), 1);
    check({shutter, v2, tg, h1, h2, sg, rg, pv, pdum, done} == '0 && pidx == '0,
          "R11 outputs low after reset", int'({shutter, v2, h1, h2, rg, pv, done}), 0);
  endtask

  task automatic t_nominal();
    run_frame("nominal", 5, 4, 3, 5, 2, 1, 5, 4, 3, 5, 2, 1, 1'b0);
  endtask

  task automatic t_alt_pattern();
    run_frame("alt", 9, 6, 4, 7, 3, 0, 9, 6, 4, 7, 3, 0, 1'b0);
  endtask

  task automatic t_clamp_low();
    // R9: zero inputs pulled to minima; sample delay 9 cut to hw-1 = 1
    run_frame("R9 clamp low", 0, 0, 0, 0, 0, 9, 1, P_MIN_VW, P_MIN_HW, P_MIN_OVR, P_MIN_RG, 1, 1'b0);
  endtask

  task automatic t_clamp_high();
    // R9: vertical width capped at MAX_VW; R6 reset width capped at hw
    run_frame("R9 clamp high", 3, 50, 3, 4, 9, 0, 3, P_MAX_VW, 3, 4, 3, 0, 1'b0);
  endtask

  task automatic t_busy_start();
    // R10 stray start, R9 mid-frame input changes ignored
    run_frame("R9 busy", 4, 5, 3, 6, 2, 2, 4, 5, 3, 6, 2, 2, 1'b1);
  endtask

  task automatic t_back_to_back();
    set_cfg(3, 4, 2, 4, 1, 1);
    e_vw = 4; e_hw = 2; e_rg = 1; e_sd = 1;
    clr_stats();
    pulse_start();
    wait_done(1'b1, "b2b first");
    check_frame("b2b first", 3, 4);
    clr_stats();
    @(negedge clk); #1 start = 1'b0;
    wait_done(1'b0, "R10 b2b second");
    repeat (4) @(negedge clk);
    #1;
    check_frame("R10 b2b second", 3, 4);
  endtask

  initial begin
    clr_stats();
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    t_reset();
    t_nominal();
    t_alt_pattern();
    t_clamp_low();
    t_clamp_high();
    t_busy_start();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule